// File: doc/BRIEF.md
# Monochrome Glyph Expander

The block turns one-bit-per-pixel glyph rows into coloured pixel writes for a drawing pipeline. A host programs a row width, a packed start position, a packed position step, a foreground colour, a background colour and a background mode. It then pushes glyph rows through a valid/ready data port. The engine emits each row as a stream of (x, y, colour) pixel writes on a valid/ready pixel port. After the row it moves its running position by the step, so the next row lands where the host wants it. The usual step is one line down.

Images wider than one row word are drawn as several columns of at most 32 pixels. The host reprograms the start position for each column. Pixels whose glyph bit is clear are either painted in the background colour or left out of the stream, depending on the mode.

Top module: `glyph_expander`

## Requirements
- R1: After reset `row_ready` is 1 and `px_valid` is 0. The width is 32, the running position is 0, the step is Y+1/X+0 (0x0001_0000), the mode is opaque and both colours are 0.
- R2: The width register (address 0, bits 5:0) sets how many pixels each row yields, from 1 to 32. A value of 0 or above 32 is treated as 32.
- R3: Pixel i of a row (i = 0 upward) comes from row bit 31-i, at x = X+i mod 2^16 and y = Y. Row bits below the width are ignored.
- R4: With mode (address 5, bits 1:0) equal to 2, set bits give the foreground colour (address 3) and clear bits give the background colour (address 4).
- R5: With mode 3, clear bits produce no pixel write. Any mode value other than 3 behaves as opaque.
- R6: The position (address 1) packs Y in bits 31:16 and X in bits 15:0, and the step (address 2) uses the same packing. When a row completes, Y and X each grow by their step field, mod 2^16.
- R7: Writing the position sets the running position. If that write falls in the cycle in which a row completes, the written value is kept and no step is added.
- R8: A write to address 6 loads both colours from 64-bit data: foreground from bits 63:32, background from bits 31:0.
- R9: `row_ready` is 0 from the cycle after a row is accepted until the cycle after its last pixel is handed off or skipped. While `px_valid` is 1 and `px_ready` is 0, the pixel outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register address |
| cfg_wdata | input | 64 | register write data (bits 31:0 unless address 6) |
| row_valid | input | 1 | glyph row offered |
| row_data | input | 32 | glyph row, leftmost pixel in bit 31 |
| row_ready | output | 1 | engine accepts a row |
| px_valid | output | 1 | pixel write offered |
| px_ready | input | 1 | pixel write taken |
| px_x | output | 16 | pixel X |
| px_y | output | 16 | pixel Y |
| px_color | output | 32 | pixel colour |

## Verification
A host position write and the step applied at the end of a row can land on the same clock edge. The bench provokes this by holding `px_ready` high so the end of the row is known exactly. It then places the position write on the edge of the last pixel handoff, and in a second run one edge earlier. It judges the outcome from the coordinates of the next row's pixels: the first run must show the written position, and the second must show the written position plus one step. The remaining runs sweep every width in each mode under random backpressure, against a stream model computed in the bench.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    localparam int ROW_W   = 32;
    localparam int COORD_W = 16;
    localparam int COLOR_W = 32;
    localparam int IDX_W   = $clog2(ROW_W);
    localparam int WID_W   = IDX_W + 1;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_WIDTH = 3'd0;
    localparam logic [ADDR_W-1:0] A_POS   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STEP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FG    = 3'd3;
    localparam logic [ADDR_W-1:0] A_BG    = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_PAIR  = 3'd6;

    localparam logic [1:0] MODE_OPAQUE = 2'd2;
    localparam logic [1:0] MODE_CLEAR  = 2'd3;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } pos_t;

    typedef struct packed {
        logic [WID_W-1:0]   width;
        logic               transparent;
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
    } row_cfg_t;

    typedef enum logic {ST_IDLE, ST_EMIT} eng_st_t;

    function automatic pos_t pos_step(input pos_t a, input pos_t b);
        pos_t r;
        r.y = a.y + b.y;
        r.x = a.x + b.x;
        return r;
    endfunction

    function automatic logic [WID_W-1:0] width_fix(input logic [WID_W-1:0] w);
        if (w == '0 || w > WID_W'(ROW_W))
            return WID_W'(ROW_W);
        return w;
    endfunction
endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [63:0]         cfg_wdata,
    input  logic                row_done,
    output pos_t                run_pos,
    output row_cfg_t            cfg
);
    logic [WID_W-1:0]   width_q;
    logic [1:0]         mode_q;
    logic [COLOR_W-1:0] fg_q, bg_q;
    pos_t               pos_q, step_q;
    logic               pos_wr;

    assign pos_wr = cfg_we && cfg_addr == A_POS;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= WID_W'(ROW_W);
            mode_q  <= MODE_OPAQUE;
            fg_q    <= '0;
            bg_q    <= '0;
            pos_q   <= '0;
            step_q  <= '{y: COORD_W'(1), x: '0};
        end else begin
            if (cfg_we) begin
                case (cfg_addr)
                    A_WIDTH: width_q <= cfg_wdata[WID_W-1:0];
                    A_STEP:  step_q  <= cfg_wdata[2*COORD_W-1:0];
                    A_FG:    fg_q    <= cfg_wdata[COLOR_W-1:0];
                    A_BG:    bg_q    <= cfg_wdata[COLOR_W-1:0];
                    A_MODE:  mode_q  <= cfg_wdata[1:0];
                    A_PAIR: begin
                        fg_q <= cfg_wdata[32+COLOR_W-1:32];
                        bg_q <= cfg_wdata[COLOR_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (pos_wr)
                pos_q <= cfg_wdata[2*COORD_W-1:0];
            else if (row_done)
                pos_q <= pos_step(pos_q, step_q);
        end
    end

    assign run_pos         = pos_q;
    assign cfg.width       = width_fix(width_q);
    assign cfg.transparent = (mode_q == MODE_CLEAR);
    assign cfg.fg          = fg_q;
    assign cfg.bg          = bg_q;

    // R2
    width_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.width >= WID_W'(1) && cfg.width <= WID_W'(ROW_W));

    // R7
    pos_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pos_wr |=> run_pos == $past(cfg_wdata[2*COORD_W-1:0]));
endmodule

// File: rtl/glyph_row_engine.sv
module glyph_row_engine
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                row_valid,
    input  logic [ROW_W-1:0]    row_data,
    output logic                row_ready,
    input  pos_t                run_pos,
    input  row_cfg_t            cfg,
    output logic                px_valid,
    input  logic                px_ready,
    output pos_t                px_pos,
    output logic [COLOR_W-1:0]  px_color,
    output logic                row_done
);
    eng_st_t          st_q;
    logic [ROW_W-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;
    pos_t             base_q;
    row_cfg_t         lat_q;
    logic             cur_bit, step, last;

    assign cur_bit   = sh_q[ROW_W-1];
    assign row_ready = (st_q == ST_IDLE);
    assign px_valid  = (st_q == ST_EMIT) && (cur_bit || !lat_q.transparent);
    assign step      = (st_q == ST_EMIT) && (!px_valid || px_ready);
    assign last      = ({1'b0, idx_q} == lat_q.width - WID_W'(1));
    assign row_done  = step && last;
    assign px_pos.y  = base_q.y;
    assign px_pos.x  = base_q.x + COORD_W'(idx_q);
    assign px_color  = cur_bit ? lat_q.fg : lat_q.bg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            idx_q  <= '0;
            base_q <= '0;
            lat_q  <= '0;
        end else if (st_q == ST_IDLE) begin
            if (row_valid) begin
                st_q   <= ST_EMIT;
                sh_q   <= row_data;
                idx_q  <= '0;
                base_q <= run_pos;
                lat_q  <= cfg;
            end
        end else if (step) begin
            if (last) begin
                st_q <= ST_IDLE;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
                sh_q  <= sh_q << 1;
            end
        end
    end

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        px_valid && !px_ready |=> px_valid && $stable(px_pos) && $stable(px_color));

    // R9
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(row_ready && px_valid));

    // R3
    row_line_chk: assert property (@(posedge clk) disable iff (rst)
        !row_ready && $past(!row_ready) |-> $stable(px_pos.y));

    // R5
    clear_fg_only_chk: assert property (@(posedge clk) disable iff (rst)
        px_valid && lat_q.transparent |-> px_color == lat_q.fg);
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [63:0]         cfg_wdata,
    input  logic                row_valid,
    input  logic [ROW_W-1:0]    row_data,
    output logic                row_ready,
    output logic                px_valid,
    input  logic                px_ready,
    output logic [COORD_W-1:0]  px_x,
    output logic [COORD_W-1:0]  px_y,
    output logic [COLOR_W-1:0]  px_color
);
    pos_t     run_pos, px_pos;
    row_cfg_t cfg;
    logic     row_done;

    glyph_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .row_done  (row_done),
        .run_pos   (run_pos),
        .cfg       (cfg)
    );

    glyph_row_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .row_valid (row_valid),
        .row_data  (row_data),
        .row_ready (row_ready),
        .run_pos   (run_pos),
        .cfg       (cfg),
        .px_valid  (px_valid),
        .px_ready  (px_ready),
        .px_pos    (px_pos),
        .px_color  (px_color),
        .row_done  (row_done)
    );

    assign px_x = px_pos.x;
    assign px_y = px_pos.y;
endmodule

// File: tb/glyph_expander_test.sv
module glyph_expander_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [63:0] cfg_wdata = 0;
    logic        row_valid = 0;
    logic [31:0] row_data = 0;
    logic        row_ready, px_valid;
    logic        px_ready = 0;
    logic [15:0] px_x, px_y;
    logic [31:0] px_color;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit force_ready = 0;
    logic [15:0] lfsr = 16'hACE1;

    // model state
    logic [15:0] m_y = 0, m_x = 0, s_y = 1, s_x = 0;
    logic [31:0] m_fg = 0, m_bg = 0;
    int          m_w = 32;
    logic [1:0]  m_mode = 2;
    logic [63:0] expq[$];

    glyph_expander uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            px_ready = force_ready ? 1'b1 : (lfsr[0] | lfsr[3]);
        end
    end

    // pixel monitor: a handshake seen here completes at the next edge
    always @(negedge clk) begin
        if (!rst && px_valid && px_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R3/R5 extra pixel", {px_y, px_x, px_color}, 64'h0);
            end else begin
                logic [63:0] e;
                e = expq.pop_front();
                chk({px_y, px_x, px_color} === e, "R3/R4/R5/R6 pixel", {px_y, px_x, px_color}, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
        case (a)
            0: m_w = (d[5:0] == 0 || d[5:0] > 32) ? 32 : int'(d[5:0]);
            1: begin m_y = d[31:16]; m_x = d[15:0]; end
            2: begin s_y = d[31:16]; s_x = d[15:0]; end
            3: m_fg = d[31:0];
            4: m_bg = d[31:0];
            5: m_mode = d[1:0];
            6: begin m_fg = d[63:32]; m_bg = d[31:0]; end
            default: ;
        endcase
    endtask

    task automatic expect_row(input logic [31:0] d);
        for (int i = 0; i < m_w; i++) begin
            logic [15:0] xi;
            xi = m_x + 16'(i);
            if (d[31-i]) expq.push_back({m_y, xi, m_fg});
            else if (m_mode != 2'd3) expq.push_back({m_y, xi, m_bg});
        end
    endtask

    task automatic offer(input logic [31:0] d);
        @(posedge clk); #1;
        row_valid = 1; row_data = d;
        forever begin
            @(negedge clk);
            if (row_ready) break;
        end
        @(posedge clk); #1;
        row_valid = 0; row_data = 32'h5A5A_0F0F;
        @(negedge clk);
        chk(row_ready == 0, "R9 busy after accept", {63'h0, row_ready}, 64'h0);
    endtask

    task automatic finish_row;
        int guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (row_ready && expq.size() == 0) break;
            if (guard > 500) break;
        end
        chk(expq.size() == 0, "R2/R3 row pixel count", 64'(expq.size()), 64'h0);
        expq.delete();
    endtask

    task automatic send_row(input logic [31:0] d);
        expect_row(d);
        offer(d);
        finish_row();
        m_y = m_y + s_y; m_x = m_x + s_x;
    endtask

    // position write placed 'off' edges before the row's final handoff
    task automatic collide(input logic [31:0] d, input int off, input logic [31:0] np);
        expect_row(d);
        @(posedge clk); #1;
        row_valid = 1; row_data = d;
        forever begin
            @(negedge clk);
            if (row_ready) break;
        end
        @(posedge clk); #1;
        row_valid = 0;
        repeat (m_w - 1 - off) @(posedge clk);
        #1; cfg_we = 1; cfg_addr = 3'd1; cfg_wdata = {32'h0, np};
        @(posedge clk); #1;
        cfg_we = 0;
        finish_row();
        m_y = np[31:16]; m_x = np[15:0];
        if (off != 0) begin m_y = m_y + s_y; m_x = m_x + s_x; end
    endtask

    initial begin
        #2000000;
        chk(0, "watchdog", 64'h0, 64'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        logic [31:0] steps [3];
        logic [1:0]  modes [3];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0;
        pats[2] = 32'hA5C3_3C5A; pats[3] = 32'h8000_0001;
        steps[0] = 32'h0001_0000; steps[1] = 32'h0002_0020; steps[2] = 32'hFFFF_0003;
        modes[0] = 2'd2; modes[1] = 2'd3; modes[2] = 2'd0;

        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1
        chk(row_ready == 1, "R1 ready after reset", {63'h0, row_ready}, 64'h1);
        chk(px_valid == 0, "R1 idle after reset", {63'h0, px_valid}, 64'h0);
        // R1: reset width 32, opaque, colours 0, position 0
        send_row(32'h0F00_00F1);
        // R1: reset step is one line down
        send_row(32'h1234_5678);

        // R8 colour pair
        wr(3'd6, 64'hCAFE_0001_0BAD_0002);
        send_row(32'hF0F0_0000);

        // R2..R6 sweep: modes, widths, patterns, steps
        for (int m = 0; m < 3; m++) begin
            wr(3'd5, {62'h0, modes[m]});
            wr(3'd2, {32'h0, steps[m]});
            wr(3'd1, 64'h0000_0000_FFF0_FFE8);
            wr(3'd3, 64'(32'h00FF_0000 + m));
            wr(3'd4, 64'(32'h0000_FF00 + m));
            for (int w = 1; w <= 32; w++) begin
                wr(3'd0, 64'(w));
                for (int p = 0; p < 4; p++) send_row(pats[p] ^ 32'(w * 7));
            end
        end

        // R2 out-of-range widths behave as 32
        wr(3'd5, 64'd2);
        wr(3'd0, 64'd0);
        send_row(32'h0123_4567);
        wr(3'd0, 64'd45);
        send_row(32'h89AB_CDEF);

        // R3 bits below width ignored (low bits set, width 4)
        wr(3'd0, 64'd4);
        wr(3'd6, 64'h0000_0011_0000_0022);
        send_row(32'hA0FF_FFFF);

        // R7 collisions with ready held high
        force_ready = 1;
        wr(3'd2, 64'h0001_0000);
        wr(3'd0, 64'd6);
        repeat (2) @(posedge clk);
        collide(32'hB400_0000, 0, 32'h0040_0100);
        send_row(32'hFC00_0000);
        collide(32'h4800_0000, 1, 32'h0070_0200);
        send_row(32'hFC00_0000);
        wr(3'd0, 64'd1);
        collide(32'h8000_0000, 0, 32'h0003_0004);
        send_row(32'h8000_0000);
        // R7 plain position write
        wr(3'd1, 64'h0000_0000_1111_2222);
        send_row(32'h0000_0000);
        force_ready = 0;

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule